// File: doc/BRIEF.md
# Variable-Length Instruction Length Scanner

This block sits behind an instruction fetch unit that delivers code as a stream of 16-bit parcels. It keeps a small queue of parcels and works out how many parcels the instruction at the head of the queue occupies. The length comes only from low-order bit patterns of the head parcel. Once every parcel of that instruction is in the queue, the block presents it as one assembled word, together with its parcel count, its start address and a flag for reserved encodings.

Instructions may start on any 16-bit boundary. A flush empties the queue in the cycle it is asserted and loads a new start address, which is how a taken branch or jump redirects the scanner. Opcode decoding and expansion of short instructions are left to later stages.

Top module: `ilen_scanner`

## Requirements
- R1: A head parcel whose bits [1:0] are not 2'b11 gives out_len = 1 (a 16-bit instruction).
- R2: Bits [1:0] = 2'b11 with bits [4:2] other than 3'b111 give out_len = 2.
- R3: Bits [5:0] = 6'b011111 give out_len = 3.
- R4: Bits [6:0] = 7'b0111111 give out_len = 4.
- R5: Bits [6:0] = 7'b1111111 with n = bits [14:12] below 7 give out_len = 5 + n (80 + 16·n bits, at most 11 parcels).
- R6: Bits [6:0] = 7'b1111111 with bits [14:12] = 3'b111 is reserved. It is presented with out_illegal = 1 and out_len = 1, carrying only that parcel. The next instruction then starts at the following parcel.
- R7: out_valid stays low until every parcel of the head instruction has been accepted. It rises in the cycle after the last parcel is accepted.
- R8: The first parcel fills out_insn[15:0], parcel k fills out_insn[16k+15:16k], and every bit above the instruction's length reads 0.
- R9: out_pc is 0 after reset. A flush sets it to flush_addr with bit 0 cleared, and every accepted instruction advances it by 2·out_len. Its bit 0 is always 0.
- R10: While flush is high, in_ready is low and no parcel is taken. In the next cycle the queue is empty and out_valid is low.
- R11: While out_valid is high and out_ready is low (no flush), out_valid, out_insn, out_len, out_illegal and out_pc hold steady.
- R12: After reset out_valid is low and in_ready is high. in_ready is low while the queue holds DEPTH (default 12) parcels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard queued parcels and restart at flush_addr |
| flush_addr | input | AW | New byte start address; bit 0 is ignored |
| in_valid | input | 1 | Parcel offered |
| in_data | input | 16 | Parcel value |
| in_ready | output | 1 | Parcel accepted when high with in_valid |
| out_valid | output | 1 | Complete instruction presented |
| out_ready | input | 1 | Consumer takes the instruction |
| out_insn | output | 176 | Assembled instruction, zero above its length |
| out_len | output | 4 | Length in parcels, 1 to 11 |
| out_illegal | output | 1 | Head parcel uses the reserved encoding |
| out_pc | output | AW | Byte address of the presented instruction |

## Verification
If the queue count is wrong, out_valid rises one parcel too early or too late, or a stale parcel shows up in the upper bits of out_insn on the very next instruction. If the shift after a pop is wrong, the next instruction appears with a misread length. Its out_pc then drifts from the running sum of lengths, and from that point every later instruction is off. The bench sweeps all 128 values of the low seven bits against all eight values of bits [14:12]. Each case is streamed one parcel at a time, so a fault shows up within one instruction of the pattern that triggers it.

// File: rtl/ilen_scanner.sv
module ilen_scanner #(
  parameter int AW    = 32,
  parameter int DEPTH = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  input  logic          in_valid,
  input  logic [15:0]   in_data,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [175:0]  out_insn,
  output logic [3:0]    out_len,
  output logic          out_illegal,
  output logic [AW-1:0] out_pc
);
  localparam int MAXP = 11;
  localparam int CW   = $clog2(DEPTH + 1);

  logic [15:0]   pq [DEPTH];
  logic [15:0]   pq_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] pc_q;
  logic [3:0]    need, pop_n;
  logic          rsv, push, pop;

  wire [15:0] head = pq[0];
  wire [2:0]  nfld = head[14:12];

  always_comb begin
    rsv = 1'b0;
    if (head[1:0] != 2'b11)       need = 4'd1;
    else if (head[4:2] != 3'b111) need = 4'd2;
    else if (!head[5])            need = 4'd3;
    else if (!head[6])            need = 4'd4;
    else if (nfld != 3'b111)      need = 4'd5 + {1'b0, nfld};
    else begin                    need = 4'd1; rsv = 1'b1; end
  end

  assign in_ready    = !flush && (int'(cnt_q) < DEPTH);
  assign out_valid   = (cnt_q != '0) && (int'(cnt_q) >= int'(need));
  assign out_len     = need;
  assign out_illegal = rsv && out_valid;
  assign out_pc      = pc_q;
  assign push        = in_valid && in_ready;
  assign pop         = out_valid && out_ready && !flush;
  assign pop_n       = pop ? need : 4'd0;
  assign cnt_d       = cnt_q - CW'(pop_n) + CW'(push);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      pq_d[i] = (i + int'(pop_n) < DEPTH) ? pq[i + int'(pop_n)] : 16'h0;
      if (push && i == int'(cnt_q) - int'(pop_n)) pq_d[i] = in_data;
    end
  end

  always_comb begin
    out_insn = '0;
    for (int k = 0; k < MAXP; k++)
      if (k < int'(need) && k < DEPTH) out_insn[16*k +: 16] = pq[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pc_q  <= '0;
      for (int i = 0; i < DEPTH; i++) pq[i] <= 16'h0;
    end else if (flush) begin
      cnt_q <= '0;
      pc_q  <= {flush_addr[AW-1:1], 1'b0};
    end else begin
      cnt_q <= cnt_d;
      pc_q  <= pc_q + (AW'(pop_n) << 1);
      for (int i = 0; i < DEPTH; i++) pq[i] <= pq_d[i];
    end
  end

  assert_reserved_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_len == 4'd1);

  assert_pc_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_pc[0]);

  assert_pc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !flush) |=> out_pc == $past(out_pc) + (AW'($past(out_len)) << 1));

  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> out_valid && $stable(out_insn) && $stable(out_pc));

  assert_full_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt_q) >= DEPTH) |-> !in_ready);
endmodule

// File: tb/sim_ilen_scanner.sv
module sim_ilen_scanner;
  logic clk = 0, rst_n = 0, flush = 0, in_valid = 0, out_ready = 0;
  logic [31:0] flush_addr = '0;
  logic [15:0] in_data = '0;
  logic in_ready, out_valid, out_illegal;
  logic [175:0] out_insn;
  logic [3:0] out_len;
  logic [31:0] out_pc;
  int errs = 0, checks = 0;
  logic [31:0] exp_pc = '0;

  always #4 clk = ~clk;

  ilen_scanner u0 (.clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_insn(out_insn), .out_len(out_len),
    .out_illegal(out_illegal), .out_pc(out_pc));

  task automatic chk(input string req, input logic [175:0] act, input logic [175:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_len(input logic [15:0] p, output bit bad);
    bad = 0;
    if (p[1:0] != 2'b11) return 1;
    if (p[4:2] != 3'b111) return 2;
    if (p[5:0] == 6'b011111) return 3;
    if (p[6:0] == 7'b0111111) return 4;
    if (p[14:12] != 3'b111) return 5 + int'(p[14:12]);
    bad = 1;
    return 1;
  endfunction

  task automatic push(input logic [15:0] d);
    in_valid = 1; in_data = d;
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic pop_one;
    out_ready = 1;
    @(posedge clk); #1;
    out_ready = 0;
  endtask

  task automatic run_one(input logic [15:0] first);
    bit bad;
    int L;
    logic [175:0] exp_w;
    L = ref_len(first, bad);
    exp_w = '0;
    for (int k = 0; k < L; k++) begin
      logic [15:0] d;
      d = (k == 0) ? first : 16'(k * 16'h1357) ^ first;
      exp_w[16*k +: 16] = d;
      if (k > 0) chk("R7 early valid", 176'(out_valid), 176'(0));
      push(d);
    end
    chk("R7 valid after last parcel", 176'(out_valid), 176'(1));
    if (bad) chk("R6 illegal flag", 176'(out_illegal), 176'(1));
    else if (L == 1) chk("R1 len", 176'(out_len), 176'(1));
    else if (L == 2) chk("R2 len", 176'(out_len), 176'(2));
    else if (L == 3) chk("R3 len", 176'(out_len), 176'(3));
    else if (L == 4) chk("R4 len", 176'(out_len), 176'(4));
    else chk("R5 len", 176'(out_len), 176'(L));
    if (!bad) chk("R6 no flag", 176'(out_illegal), 176'(0));
    else chk("R6 len", 176'(out_len), 176'(1));
    chk("R8 insn", out_insn, exp_w);
    chk("R9 pc", 176'(out_pc), 176'(exp_pc));
    @(posedge clk); #1;
    chk("R11 hold insn", out_insn, exp_w);
    chk("R11 hold valid", 176'(out_valid), 176'(1));
    pop_one();
    exp_pc = exp_pc + 32'(2 * L);
    chk("R7 empty after pop", 176'(out_valid), 176'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    chk("R12 reset valid", 176'(out_valid), 176'(0));
    chk("R12 reset ready", 176'(in_ready), 176'(1));
    chk("R9 reset pc", 176'(out_pc), 176'(0));

    for (int lo = 0; lo < 128; lo++)
      for (int n = 0; n < 8; n++)
        run_one({1'b0, 3'(n), 5'(lo * 3), 7'(lo)});

    // R6: reserved parcel followed by a short instruction
    push(16'h707F);
    push(16'h1234);
    chk("R6 reserved flagged", 176'(out_illegal), 176'(1));
    chk("R6 reserved data", out_insn, 176'(16'h707F));
    pop_one();
    chk("R6 next starts at following parcel", out_insn, 176'(16'h1234));
    chk("R6 next pc", 176'(out_pc), 176'(exp_pc + 2));
    pop_one();
    exp_pc = exp_pc + 4;

    // R10: flush drops partial instruction
    push(16'h003F); push(16'hAAAA); push(16'hBBBB);
    flush = 1; flush_addr = 32'h0000_1235; in_valid = 1; in_data = 16'h5555;
    #1 chk("R10 ready low during flush", 176'(in_ready), 176'(0));
    @(posedge clk); #1;
    flush = 0; in_valid = 0;
    chk("R10 valid low after flush", 176'(out_valid), 176'(0));
    chk("R9 flush pc", 176'(out_pc), 176'(32'h1234));
    push(16'h4448);
    chk("R10 fresh insn only", out_insn, 176'(16'h4448));
    pop_one();
    exp_pc = 32'h1236;

    // R12: fill queue with short instructions
    for (int k = 0; k < 12; k++) push(16'(k * 4));
    chk("R12 ready low when full", 176'(in_ready), 176'(0));
    for (int k = 0; k < 12; k++) begin
      chk("R8 queued data", out_insn, 176'(16'(k * 4)));
      chk("R9 queued pc", 176'(out_pc), 176'(exp_pc));
      pop_one();
      exp_pc = exp_pc + 2;
    end
    chk("R12 ready after drain", 176'(in_ready), 176'(1));

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule